// File: doc/BRIEF.md
# Time-Sliced Two-Client Bus Arbiter

This block decides which of two internal clients may drive a shared bus: a receive-path client that drains an incoming FIFO and a transmit-path client that fills an outgoing FIFO. Each client raises a request and waits for its grant. While it holds the grant it moves data. It gives the bus back by pulsing its done line, by dropping its request, or by running out of time. Each grant lasts at most a fixed number of clock cycles, set by the `QUANTUM` parameter. The default of 32 cycles at 32 bits per cycle moves 128 bytes, which is one full small FIFO.

The next owner is chosen by a round robin that leans toward the receive side. On contention right after reset, or when the transmit client held the previous grant, the receive client wins. When the receive client held the previous grant, the transmit client wins. Neither client can be starved. One bus-idle cycle always separates two grants.

The block also takes an overflow strobe from each FIFO side. Each strobe sets a sticky interrupt bit that stays set until software pulses a clear. A combined interrupt line is the OR of the two bits.

Top module: `qsa_arbiter`

## Requirements
- R1: `rx_grant` and `tx_grant` are never high in the same cycle.
- R2: When a grant drops, the next grant to either client comes no earlier than the second cycle after the drop. There is always one cycle with no grant in between.
- R3: A grant stays high for at most `QUANTUM` consecutive cycles. If the owner keeps requesting and never pulses done, the grant stays high for exactly `QUANTUM` cycles.
- R4: If the owner has done high while its grant is high, the grant is low in the next cycle.
- R5: If the owner has request low while its grant is high, the grant is low in the next cycle. This counts as an early finish.
- R6: With no grant active and only one client requesting, that client's grant rises in the next cycle.
- R7: With no grant active and both clients requesting, the receive client wins if the transmit client held the most recent grant, or if no grant has happened since reset.
- R8: With no grant active and both clients requesting, the transmit client wins if the receive client held the most recent grant.
- R9: During and after reset, and while no client requests, both grants stay low.
- R10: An overflow strobe sets that side's sticky bit (`irq_rx` or `irq_tx`) in the next cycle. A set bit stays set until a cycle with `irq_clear` high and no strobe for that side. A strobe in the same cycle as a clear leaves the bit set. Reset clears both bits.
- R11: `irq` equals `irq_rx` OR `irq_tx`.
- R12: Done from a client that does not hold the grant does not affect either grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_req | input | 1 | Receive client requests the bus |
| rx_done | input | 1 | Receive client releases the bus early |
| rx_ovf | input | 1 | Receive FIFO overflow strobe |
| tx_req | input | 1 | Transmit client requests the bus |
| tx_done | input | 1 | Transmit client releases the bus early |
| tx_ovf | input | 1 | Transmit FIFO overflow strobe |
| irq_clear | input | 1 | Clears both sticky interrupt bits |
| rx_grant | output | 1 | Bus granted to the receive client |
| tx_grant | output | 1 | Bus granted to the transmit client |
| irq_rx | output | 1 | Sticky receive overflow flag |
| irq_tx | output | 1 | Sticky transmit overflow flag |
| irq | output | 1 | OR of the two sticky flags |

## Verification
The bench targets three kinds of corner case.

- **Slice boundary.** A client requests without pause so that its grant must end at exactly `QUANTUM` cycles. A counter that is off by one would hold the bus one cycle too long or too short.
- **Contention.** Both clients request right after reset, and again right after each kind of slice. A design that always favoured the receive side would starve the transmit client. A design that alternated blindly would hand the first contested grant to the transmit client.
- **Release and interrupt timing.** Done is pulsed by the non-owner, and requests are withdrawn without done. An overflow strobe and a clear arrive in the same cycle. These expose a design that reacts to the wrong client's done, that misses an early finish, or that lets the clear win.

// File: rtl/qsa_pkg.sv
package qsa_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_RX   = 2'd1,
        OWN_TX   = 2'd2
    } owner_e;

    typedef struct packed {
        logic req;
        logic done;
    } client_t;

    // Receive-biased round robin selection
    function automatic owner_e pick_owner(input logic rx_req,
                                          input logic tx_req,
                                          input logic tx_was_last);
        owner_e w;
        if (rx_req && tx_req)
            w = tx_was_last ? OWN_RX : OWN_TX;
        else if (rx_req)
            w = OWN_RX;
        else if (tx_req)
            w = OWN_TX;
        else
            w = OWN_NONE;
        return w;
    endfunction

endpackage

// File: rtl/qsa_pick.sv
module qsa_pick
    import qsa_pkg::*;
(
    input  client_t rx_c,
    input  client_t tx_c,
    input  logic    tx_was_last,
    output owner_e  winner
);
    always_comb winner = pick_owner(rx_c.req, tx_c.req, tx_was_last);
endmodule

// File: rtl/qsa_slice_timer.sv
module qsa_slice_timer #(
    parameter int QUANTUM = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = $clog2(QUANTUM + 1);
    localparam logic [CNT_W-1:0] Q_LIM = CNT_W'(QUANTUM);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CNT_W'(1);
        else if (run && cnt_q != Q_LIM)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign expire = run && (cnt_q == Q_LIM);
endmodule

// File: rtl/qsa_sticky_flag.sv
module qsa_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else
            flag_o <= set_i | (flag_o & ~clr_i);
    end
endmodule

// File: rtl/qsa_arbiter.sv
module qsa_arbiter
    import qsa_pkg::*;
#(
    parameter int QUANTUM = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_req,
    input  logic rx_done,
    input  logic rx_ovf,
    input  logic tx_req,
    input  logic tx_done,
    input  logic tx_ovf,
    input  logic irq_clear,
    output logic rx_grant,
    output logic tx_grant,
    output logic irq_rx,
    output logic irq_tx,
    output logic irq
);
    localparam int NSRC = 2;

    client_t rx_c, tx_c;
    owner_e  owner_q, owner_d, winner;
    logic    tx_was_last_q;
    logic    start, expire, release_now;
    logic [NSRC-1:0] ovf_vec, flag_vec;

    assign rx_c = '{req: rx_req, done: rx_done};
    assign tx_c = '{req: tx_req, done: tx_done};

    qsa_pick pick_i (
        .rx_c        (rx_c),
        .tx_c        (tx_c),
        .tx_was_last (tx_was_last_q),
        .winner      (winner)
    );

    qsa_slice_timer #(.QUANTUM(QUANTUM)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .run    (owner_q != OWN_NONE),
        .expire (expire)
    );

    always_comb begin
        unique case (owner_q)
            OWN_RX:  release_now = rx_c.done || !rx_c.req || expire;
            OWN_TX:  release_now = tx_c.done || !tx_c.req || expire;
            default: release_now = 1'b0;
        endcase
    end

    always_comb begin
        owner_d = owner_q;
        start   = 1'b0;
        if (owner_q == OWN_NONE) begin
            owner_d = winner;
            start   = (winner != OWN_NONE);
        end else if (release_now) begin
            owner_d = OWN_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q       <= OWN_NONE;
            tx_was_last_q <= 1'b1;
        end else begin
            owner_q <= owner_d;
            if (start)
                tx_was_last_q <= (owner_d == OWN_TX);
        end
    end

    assign rx_grant = (owner_q == OWN_RX);
    assign tx_grant = (owner_q == OWN_TX);

    assign ovf_vec = {tx_ovf, rx_ovf};

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        qsa_sticky_flag flag_i (
            .clk    (clk),
            .rst    (rst),
            .set_i  (ovf_vec[i]),
            .clr_i  (irq_clear),
            .flag_o (flag_vec[i])
        );
    end

    assign irq_rx = flag_vec[0];
    assign irq_tx = flag_vec[1];
    assign irq    = |flag_vec;
endmodule

// File: rtl/qsa_arbiter_chk.sv
module qsa_arbiter_chk #(
    parameter int QUANTUM = 32
) (
    input logic clk,
    input logic rst,
    input logic rx_req,
    input logic rx_done,
    input logic rx_ovf,
    input logic tx_req,
    input logic tx_done,
    input logic tx_ovf,
    input logic irq_clear,
    input logic rx_grant,
    input logic tx_grant,
    input logic irq_rx,
    input logic irq_tx,
    input logic irq
);
    localparam int RW = $clog2(QUANTUM + 2);

    logic [RW-1:0] run_len;
    logic          last_tx_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len   <= '0;
            last_tx_c <= 1'b1;
        end else begin
            if (rx_grant || tx_grant) begin
                if (run_len != RW'(QUANTUM + 1))
                    run_len <= run_len + RW'(1);
            end else begin
                run_len <= '0;
            end
            if (rx_grant)      last_tx_c <= 1'b0;
            else if (tx_grant) last_tx_c <= 1'b1;
        end
    end

    p_one_grant_r1: assert property (@(posedge clk) disable iff (rst)
        !(rx_grant && tx_grant));

    p_gap_rx_r2: assert property (@(posedge clk) disable iff (rst)
        rx_grant |=> !tx_grant);

    p_gap_tx_r2: assert property (@(posedge clk) disable iff (rst)
        tx_grant |=> !rx_grant);

    p_quantum_r3: assert property (@(posedge clk) disable iff (rst)
        run_len <= RW'(QUANTUM));

    p_done_rx_r4: assert property (@(posedge clk) disable iff (rst)
        (rx_grant && rx_done) |=> !rx_grant);

    p_done_tx_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_grant && tx_done) |=> !tx_grant);

    p_withdraw_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_grant && !tx_req) |=> !tx_grant);

    p_bias_rx_r7: assert property (@(posedge clk) disable iff (rst)
        (!rx_grant && !tx_grant && rx_req && tx_req && last_tx_c) |=> rx_grant);

    p_alt_tx_r8: assert property (@(posedge clk) disable iff (rst)
        (!rx_grant && !tx_grant && rx_req && tx_req && !last_tx_c) |=> tx_grant);

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!rx_req && !tx_req) |=> (!rx_grant && !tx_grant));

    p_sticky_set_r10: assert property (@(posedge clk) disable iff (rst)
        rx_ovf |=> irq_rx);

    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_tx && !irq_clear) |=> irq_tx);

    always_comb begin
        a_irq_or_r11: assert (irq == (irq_rx | irq_tx));
    end
endmodule

bind qsa_arbiter qsa_arbiter_chk #(.QUANTUM(QUANTUM)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rx_req    (rx_req),
    .rx_done   (rx_done),
    .rx_ovf    (rx_ovf),
    .tx_req    (tx_req),
    .tx_done   (tx_done),
    .tx_ovf    (tx_ovf),
    .irq_clear (irq_clear),
    .rx_grant  (rx_grant),
    .tx_grant  (tx_grant),
    .irq_rx    (irq_rx),
    .irq_tx    (irq_tx),
    .irq       (irq)
);

// File: tb/qsa_arbiter_tb.sv
module qsa_arbiter_tb_top;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_req = 0, rx_done = 0, rx_ovf = 0;
    logic tx_req = 0, tx_done = 0, tx_ovf = 0;
    logic irq_clear = 0;
    logic rx_grant, tx_grant, irq_rx, irq_tx, irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // reference state: 0 none, 1 rx, 2 tx
    int m_own = 0;
    int m_cnt = 0;
    bit m_last_tx = 1;
    bit m_irx = 0, m_itx = 0;

    always #2 clk = ~clk;

    qsa_arbiter #(.QUANTUM(Q)) dut_i (
        .clk(clk), .rst(rst),
        .rx_req(rx_req), .rx_done(rx_done), .rx_ovf(rx_ovf),
        .tx_req(tx_req), .tx_done(tx_done), .tx_ovf(tx_ovf),
        .irq_clear(irq_clear),
        .rx_grant(rx_grant), .tx_grant(tx_grant),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .irq(irq)
    );

    function automatic int choose(bit rq, bit tq, bit last_tx);
        if (rq && tq) return last_tx ? 1 : 2;
        if (rq) return 1;
        if (tq) return 2;
        return 0;
    endfunction

    task automatic check(string tag, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
        end
    endtask

    task automatic model_update();
        int w;
        bit rel;
        if (rst) begin
            m_own = 0; m_cnt = 0; m_last_tx = 1; m_irx = 0; m_itx = 0;
        end else begin
            if (m_own == 0) begin
                w = choose(rx_req, tx_req, m_last_tx);
                if (w != 0) begin
                    m_own = w; m_cnt = 1; m_last_tx = (w == 2);
                end
            end else begin
                if (m_own == 1) rel = rx_done || !rx_req || (m_cnt == Q);
                else            rel = tx_done || !tx_req || (m_cnt == Q);
                if (rel) m_own = 0;
                else     m_cnt++;
            end
            m_irx = rx_ovf | (m_irx & ~irq_clear);
            m_itx = tx_ovf | (m_itx & ~irq_clear);
        end
    endtask

    // advance one clock and compare at the following falling edge
    task automatic step(string gtag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        check({gtag, " rx_grant"}, rx_grant, m_own == 1);
        check({gtag, " tx_grant"}, tx_grant, m_own == 2);
        check("R1 exclusive", rx_grant & tx_grant, 1'b0);
        check("R10 irq_rx", irq_rx, m_irx);
        check("R10 irq_tx", irq_tx, m_itx);
        check("R11 irq", irq, m_irx | m_itx);
    endtask

    task automatic idle_inputs();
        rx_req = 0; rx_done = 0; rx_ovf = 0;
        tx_req = 0; tx_done = 0; tx_ovf = 0; irq_clear = 0;
    endtask

    initial begin
        void'($urandom(32'h0000_51CE));
        @(negedge clk);
        step("R9");
        step("R9");
        rst = 0;
        // R9: reset state
        check("R9 rx_grant reset", rx_grant, 1'b0);
        check("R9 tx_grant reset", tx_grant, 1'b0);
        check("R10 irq reset", irq, 1'b0);
        step("R9");

        // R7: contention straight after reset goes to receive side
        rx_req = 1; tx_req = 1;
        step("R7");
        check("R7 rx first after reset", rx_grant, 1'b1);
        // R3: receive keeps requesting, full slice
        for (int i = 1; i < Q; i++) step("R3");
        check("R3 still held at quantum", rx_grant, 1'b1);
        step("R3");
        check("R3 dropped after quantum", rx_grant, 1'b0);
        // R8: next contested grant goes to transmit side
        step("R8");
        check("R8 tx after rx", tx_grant, 1'b1);
        // R12: non-owner done ignored
        rx_done = 1;
        step("R12");
        check("R12 tx kept on rx_done", tx_grant, 1'b1);
        rx_done = 0;
        // R4: owner done ends slice early
        tx_done = 1;
        step("R4");
        tx_done = 0;
        check("R4 tx dropped on done", tx_grant, 1'b0);
        // R2 / R7: gap then receive after transmit
        step("R7");
        check("R7 rx after tx", rx_grant, 1'b1);
        // R5: withdrawal without done
        rx_req = 0; tx_req = 0;
        step("R5");
        check("R5 rx dropped on withdraw", rx_grant, 1'b0);
        step("R9");
        check("R9 idle no grant", rx_grant | tx_grant, 1'b0);
        // R6: lone transmit requester
        tx_req = 1;
        step("R6");
        check("R6 lone tx granted", tx_grant, 1'b1);
        tx_req = 0;
        step("R5");

        // R10: overflow and clear in the same cycle keeps bit set
        rx_ovf = 1;
        step("R10");
        rx_ovf = 0; tx_ovf = 1; irq_clear = 1;
        step("R10");
        check("R10 clear wins over held", irq_rx, 1'b0);
        check("R10 set beats clear", irq_tx, 1'b1);
        tx_ovf = 0; irq_clear = 0;
        step("R10");
        check("R10 sticky hold", irq_tx, 1'b1);
        check("R11 irq or", irq, 1'b1);
        irq_clear = 1;
        step("R10");
        irq_clear = 0;

        // random phase
        for (int n = 0; n < 4000; n++) begin
            rx_req    = ($urandom_range(99) < 65);
            tx_req    = ($urandom_range(99) < 65);
            rx_done   = ($urandom_range(99) < 8);
            tx_done   = ($urandom_range(99) < 8);
            rx_ovf    = ($urandom_range(99) < 3);
            tx_ovf    = ($urandom_range(99) < 3);
            irq_clear = ($urandom_range(99) < 6);
            step("R3");
        end
        idle_inputs();
        step("R9");
        step("R9");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule